// File: doc/BRIEF.md
# Memory Row Boundary Decoder

This block decides which of a small number of memory rows (chip-select groups) owns a physical address. Each row has an 8-bit upper-limit register whose value counts in 16 MB units, so the value sits at address bit 24 and above. The limits are cumulative. Row 0 starts at address zero, and every later row starts where the row before it ends. A row whose limit equals the limit of the row before it holds no memory and is never chosen.

The limit registers are loaded through a byte-wide register port with a write strobe, a row select and read-back data. The decode from address to row is purely combinational from the stored limits. It gives a one-hot chip select, the binary row number and a flag for addresses that no row claims. Memory type and ECC choices are global to the memory system and play no part here.

Top module: `mem_row_decoder`

## Requirements
- R1: After reset every limit register reads 0, so every row is empty: `no_row` is 1 and `row_cs` is 0 for any address.
- R2: When `cfg_we` is 1 at a rising clock edge, `cfg_wdata` is stored in the limit register selected by `cfg_sel` (0 to 3 pick rows 0 to 3). `cfg_rdata` always shows the register selected by `cfg_sel`.
- R3: Row i claims the addresses from base_i * 2^24 up to, but not including, limit_i * 2^24. base_0 is 0 and base_i is limit_(i-1).
- R4: A row whose limit equals its base is never selected, whatever the address.
- R5: With non-decreasing limits, any address at or above limit_3 * 2^24 sets `no_row` to 1 and `row_cs` to 0. Any address below that clears `no_row`.
- R6: `row_cs` has at most one bit set. When bit i is set, `row_idx` equals i. When no bit is set, `row_idx` is 0.
- R7: If several rows claim an address (limits programmed out of order), the lowest-numbered one wins. `no_row` is 1 exactly when no row claims the address.
- R8: The decode is combinational. A new address is decoded in the same cycle, and a newly written limit takes effect in the cycle right after its write edge.
- R9: With `cfg_we` at 0, the limit registers keep their values whatever `cfg_sel` and `cfg_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all limits |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_sel | input | 2 | Row whose limit register is written or read |
| cfg_wdata | input | 8 | Limit value to write, in 16 MB units |
| cfg_rdata | output | 8 | Limit register selected by `cfg_sel` |
| req_addr | input | 32 | Physical address to decode |
| row_cs | output | 4 | One-hot chip select of the owning row |
| row_idx | output | 2 | Number of the owning row |
| no_row | output | 1 | Address is claimed by no row |

## Verification
On every cycle the embedded properties check that the chip select is at most one-hot and agrees with the row number, and that a selected row really contains the address. They also check that writes land only when strobed, and that `no_row` matches the top-limit comparison whenever the limits are in order. Only the bench scenarios can show that the correct row wins at the exact boundary addresses. The same goes for empty rows being skipped in the middle of the map and for lowest-row priority under out-of-order limits. The bench compares its behavioural model against the design on every clock over directed maps and a long random phase.

// File: rtl/mem_row_decoder.sv
module mem_row_decoder #(
  parameter int ADDR_W     = 32,
  parameter int ROWS       = 4,
  parameter int BND_W      = 8,
  parameter int UNIT_SHIFT = 24,
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CMP_W = (ADDR_W > UNIT_SHIFT + BND_W) ? ADDR_W : UNIT_SHIFT + BND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [BND_W-1:0]  cfg_wdata,
  output logic [BND_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [ROWS-1:0]   row_cs,
  output logic [IDX_W-1:0]  row_idx,
  output logic              no_row
);

  logic [BND_W-1:0] limit_q [ROWS];
  logic [CMP_W-1:0] row_lo  [ROWS];
  logic [CMP_W-1:0] row_hi  [ROWS];
  logic [CMP_W-1:0] addr_x;
  logic [ROWS-1:0]  match;
  logic [ROWS:0]    blocked;
  logic             sel_ok;

  assign sel_ok = 32'(cfg_sel) < ROWS;
  assign addr_x = CMP_W'(req_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) limit_q[i] <= '0;
    end else if (cfg_we && sel_ok) begin
      limit_q[cfg_sel] <= cfg_wdata;
    end
  end

  assign cfg_rdata = sel_ok ? limit_q[cfg_sel] : '0;

  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    if (g == 0) begin : g_first
      assign row_lo[g] = '0;
    end else begin : g_next
      assign row_lo[g] = CMP_W'(limit_q[g-1]) << UNIT_SHIFT;
    end
    assign row_hi[g]     = CMP_W'(limit_q[g]) << UNIT_SHIFT;
    assign match[g]      = (addr_x >= row_lo[g]) && (addr_x < row_hi[g]);
    assign row_cs[g]     = match[g] & ~blocked[g];
    assign blocked[g+1]  = blocked[g] | match[g];

    // R4: a chosen row is non-empty and really contains the address
    a_r4_row_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
      row_cs[g] |-> (limit_q[g] != ((g == 0) ? '0 : limit_q[(g == 0) ? 0 : g-1]))
                    && (addr_x < row_hi[g]));
  end

  always_comb begin
    row_idx = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (match[i]) row_idx = IDX_W'(i);
    end
  end

  assign no_row = ~|match;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic ordered;
  always_comb begin
    ordered = 1'b1;
    for (int i = 1; i < ROWS; i++) begin
      if (limit_q[i] < limit_q[i-1]) ordered = 1'b0;
    end
  end

  // R1: first cycle out of reset has an empty map
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !past_ok |-> (no_row && row_cs == '0));

  // R2: a strobed write lands in the selected register
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_we) && ($past(cfg_sel) == cfg_sel)) |-> (cfg_rdata == $past(cfg_wdata)));

  // R9: without a strobe the selected register keeps its value
  a_r9_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(cfg_we) && $stable(cfg_sel)) |-> $stable(cfg_rdata));

  // R6: at most one chip select, consistent with the index
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_cs));

  a_r6_idx_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    (row_cs != '0) |-> row_cs[row_idx]);

  // R5: with ordered limits, out of range means at or above the top limit
  a_r5_top_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ordered |-> (no_row == (addr_x >= (CMP_W'(limit_q[ROWS-1]) << UNIT_SHIFT))));

  // R7: no_row only when no chip select
  a_r7_flag_vs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    no_row |-> (row_cs == '0));

endmodule

// File: tb/mem_row_decoder_tb_top.sv
`timescale 1ns/1ps
module mem_row_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [31:0] req_addr = '0;
  logic [3:0]  row_cs;
  logic [1:0]  row_idx;
  logic        no_row;

  always #2 clk = ~clk;

  mem_row_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
    .row_cs(row_cs), .row_idx(row_idx), .no_row(no_row)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int bnd [4];
  bit pend_we = 1'b0;
  int pend_sel = 0;
  int pend_wd = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int hi;
    int base;
    int win;
    hi = int'(req_addr[31:24]);
    win = -1;
    for (int r = 0; r < 4; r++) begin
      base = (r == 0) ? 0 : bnd[r-1];
      if (win < 0 && hi >= base && hi < bnd[r]) win = r;
    end
    chk(tag, "row_cs", int'(row_cs), (win < 0) ? 0 : (1 << win));
    chk(tag, "row_idx", int'(row_idx), (win < 0) ? 0 : win);
    chk(tag, "no_row", int'(no_row), (win < 0) ? 1 : 0);
    chk("R2", "cfg_rdata", int'(cfg_rdata), bnd[cfg_sel]);
  endtask

  task automatic cyc(string tag, bit we, int sel, int wd, logic [31:0] a);
    @(posedge clk);
    if (pend_we) bnd[pend_sel] = pend_wd;
    #1;
    cfg_we = we; cfg_sel = 2'(sel); cfg_wdata = 8'(wd); req_addr = a;
    pend_we = we; pend_sel = sel; pend_wd = wd;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic load(int b0, int b1, int b2, int b3);
    cyc("R2", 1'b1, 0, b0, 32'h0);
    cyc("R2", 1'b1, 1, b1, 32'h0);
    cyc("R2", 1'b1, 2, b2, 32'h0);
    cyc("R8", 1'b1, 3, b3, 32'h0);
    cyc("R8", 1'b0, 3, 0, 32'h0);
  endtask

  task automatic edges(string tag, int lim);
    cyc(tag, 1'b0, 0, 0, {8'(lim), 24'h0} - 32'h1);
    cyc(tag, 1'b0, 1, 0, {8'(lim), 24'h0});
    cyc(tag, 1'b0, 2, 0, {8'(lim), 24'h0} + 32'h0012_3456);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) bnd[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    cyc("R1", 1'b0, 0, 0, 32'h0000_0000);
    cyc("R1", 1'b0, 3, 0, 32'hFFFF_FFFF);

    load(1, 3, 7, 8);
    edges("R3", 1); edges("R3", 3); edges("R3", 7);
    edges("R5", 8);
    cyc("R5", 1'b0, 0, 0, 32'hFFFF_FFFF);

    load(2, 2, 5, 5);
    edges("R4", 2); edges("R4", 5);
    cyc("R4", 1'b0, 1, 0, 32'h0300_0000);

    cyc("R9", 1'b0, 1, 8'hAA, 32'h0100_0000);
    cyc("R9", 1'b0, 1, 8'h55, 32'h0400_0000);
    cyc("R9", 1'b0, 2, 8'h77, 32'h0400_0000);

    load(0, 0, 0, 8'hFF);
    cyc("R3", 1'b0, 0, 0, 32'h0000_0000);
    cyc("R5", 1'b0, 0, 0, 32'hFEFF_FFFF);
    cyc("R5", 1'b0, 0, 0, 32'hFF00_0000);

    load(6, 3, 8, 2);
    edges("R7", 2); edges("R7", 3); edges("R7", 6); edges("R7", 8);

    cyc("R8", 1'b1, 0, 1, 32'h0180_0000);
    cyc("R8", 1'b0, 0, 0, 32'h0180_0000);

    for (int n = 0; n < 3000; n++) begin
      cyc((n % 2 == 0) ? "R6" : "R7", ($urandom % 4) == 0, int'($urandom % 4),
          int'($urandom % 256), $urandom);
    end
    for (int n = 0; n < 500; n++) begin
      int s;
      s = int'($urandom % 4);
      if (n % 50 == 0) load(16, 48, 48, 200);
      cyc("R5", 1'b0, s, 0, $urandom);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule